// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. Within the cycle it fetches a word from a separate instruction memory, decodes it, reads two source registers, forms an ALU result, reads or writes a separate data memory, and works out the next program counter. The program counter, the register file and data memory all change together at the next rising clock edge. The cycle length is therefore set by the slowest path, which is the load: fetch, decode, register read, address add, memory read and register write-back.

The core has register-register ALU operations, the same operations with a sign-extended 16-bit immediate, load word, store word and branch-if-equal. The next program counter comes from a dedicated +4 adder and a branch-target adder, not from the main ALU. Both memories sit outside the core and are read combinationally. A debug port shows, in each cycle, the register update that will land at the next edge.

Instruction word: opcode in bits 31:26, first source (rs) in 25:21, second source or immediate destination (rt) in 20:16, register destination (rd) in 15:11, 16-bit immediate in 15:0, function code in 5:0. All immediates are sign-extended.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and clears every register to 0.
- R2: Opcode 0x00 writes rd with rs op rt, where the function code selects add 0x20, subtract 0x22, and 0x24, or 0x25, xor 0x26 and signed set-less-than 0x2A (result 1 or 0). Other function codes write nothing.
- R3: Opcodes 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor write rt with rs op sign-extended immediate.
- R4: Load (opcode 0x23) drives the data address rs + sign-extended immediate with the read strobe high and writes the returned data to rt in the same cycle.
- R5: Store (opcode 0x2B) drives the data address rs + sign-extended immediate, write data equal to rt and the write strobe high, and updates no register.
- R6: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 plus the sign-extended immediate shifted left by 2 when rs equals rt, and to PC+4 otherwise; it updates no register.
- R7: Register 0 always reads as 0; an instruction naming it as destination changes nothing and leaves the debug write strobe low.
- R8: Every instruction other than a taken branch advances the PC by 4; an unknown opcode does nothing else.
- R9: The debug port raises its strobe, with register number and data, in exactly the cycles in which a register is written at the next edge, and the written value is seen by the following instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction to fetch (current PC) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store strobe, written at the next edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Data read at dmem_addr |
| wb_en | output | 1 | Debug: a register is written at the next edge |
| wb_reg | output | 5 | Debug: destination register number |
| wb_data | output | 32 | Debug: value written |

## Verification
Every cycle, the assertions check that the PC stays word aligned, returns to zero after reset and steps by exactly four after any non-branch instruction, that register 0 never appears as a write destination, that the two memory strobes are exclusive and only raised by the matching opcodes, and that a store never writes a register. Whether each ALU result, load value and branch target is numerically right, and whether reset really cleared the register file, only the bench's program trace and directed cases can show, since they depend on the data flowing through the register file and memories.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata,
  output logic        wb_en,
  output logic [4:0]  wb_reg,
  output logic [31:0] wb_data
);
  localparam logic [5:0] OP_RR = 6'h00, OP_BEQ = 6'h04, OP_ADDI = 6'h08,
    OP_SLTI = 6'h0A, OP_ANDI = 6'h0C, OP_ORI = 6'h0D, OP_XORI = 6'h0E,
    OP_LW = 6'h23, OP_SW = 6'h2B;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24,
    FN_OR = 6'h25, FN_XOR = 6'h26, FN_SLT = 6'h2A;
  localparam logic [2:0] A_ADD = 3'd0, A_SUB = 3'd1, A_AND = 3'd2,
    A_OR = 3'd3, A_XOR = 3'd4, A_SLT = 3'd5;

  logic [31:0] pc;
  logic [31:0] rf [0:31];

  wire [5:0]  op  = imem_data[31:26];
  wire [4:0]  rs  = imem_data[25:21];
  wire [4:0]  rt  = imem_data[20:16];
  wire [4:0]  rd  = imem_data[15:11];
  wire [5:0]  fn  = imem_data[5:0];
  wire [31:0] imm = {{16{imem_data[15]}}, imem_data[15:0]};

  logic       rwrite, mread, mwrite, alu_imm, wb_mem, dst_rd, is_beq;
  logic [2:0] alu_op;

  always_comb begin
    rwrite = 1'b0; mread = 1'b0; mwrite = 1'b0; alu_imm = 1'b0;
    wb_mem = 1'b0; dst_rd = 1'b0; is_beq = 1'b0; alu_op = A_ADD;
    case (op)
      OP_RR: begin
        rwrite = 1'b1; dst_rd = 1'b1;
        case (fn)
          FN_ADD:  alu_op = A_ADD;
          FN_SUB:  alu_op = A_SUB;
          FN_AND:  alu_op = A_AND;
          FN_OR:   alu_op = A_OR;
          FN_XOR:  alu_op = A_XOR;
          FN_SLT:  alu_op = A_SLT;
          default: rwrite = 1'b0;
        endcase
      end
      OP_ADDI: begin rwrite = 1'b1; alu_imm = 1'b1; alu_op = A_ADD; end
      OP_SLTI: begin rwrite = 1'b1; alu_imm = 1'b1; alu_op = A_SLT; end
      OP_ANDI: begin rwrite = 1'b1; alu_imm = 1'b1; alu_op = A_AND; end
      OP_ORI:  begin rwrite = 1'b1; alu_imm = 1'b1; alu_op = A_OR;  end
      OP_XORI: begin rwrite = 1'b1; alu_imm = 1'b1; alu_op = A_XOR; end
      OP_LW:   begin rwrite = 1'b1; alu_imm = 1'b1; mread = 1'b1; wb_mem = 1'b1; end
      OP_SW:   begin mwrite = 1'b1; alu_imm = 1'b1; end
      OP_BEQ:  is_beq = 1'b1;
      default: ;
    endcase
  end

  wire [31:0] a = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] b_reg = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] b = alu_imm ? imm : b_reg;

  logic [31:0] alu_y;
  always_comb begin
    case (alu_op)
      A_SUB:   alu_y = a - b;
      A_AND:   alu_y = a & b;
      A_OR:    alu_y = a | b;
      A_XOR:   alu_y = a ^ b;
      A_SLT:   alu_y = {31'd0, $signed(a) < $signed(b)};
      default: alu_y = a + b;
    endcase
  end

  wire [31:0] pc4    = pc + 32'd4;
  wire [31:0] target = pc4 + {imm[29:0], 2'b00};
  wire        taken  = is_beq && (a == b_reg);
  wire [4:0]  dst    = dst_rd ? rd : rt;

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = b_reg;
  assign dmem_we    = mwrite;
  assign dmem_re    = mread;
  assign wb_en      = rwrite && (dst != 5'd0);
  assign wb_reg     = dst;
  assign wb_data    = wb_mem ? dmem_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= taken ? target : pc4;
      if (wb_en) rf[dst] <= wb_data;
    end
  end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  op,
  input logic        we,
  input logic        re,
  input logic        wen,
  input logic [4:0]  wreg
);
  a_r1_pc_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);
  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) != 6'h04) |-> pc == $past(pc) + 32'd4);
  a_r6_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
  a_r7_no_r0_write: assert property (@(posedge clk) disable iff (rst)
    wen |-> wreg != 5'd0);
  a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
    we |-> (op == 6'h2B && !wen && !re));
  a_r4_load_only: assert property (@(posedge clk) disable iff (rst)
    re |-> op == 6'h23);
endmodule

bind sc_core sc_core_chk i_chk (
  .clk(clk), .rst(rst), .pc(imem_addr), .op(imem_data[31:26]),
  .we(dmem_we), .re(dmem_re), .wen(wb_en), .wreg(wb_reg)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
  logic dmem_we, dmem_re, wb_en;
  logic [4:0] wb_reg;
  logic [31:0] imem [0:31];
  logic [31:0] dmem [0:15];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sc_core i_sc_core (.clk, .rst, .imem_addr, .imem_data, .dmem_addr, .dmem_wdata,
    .dmem_we, .dmem_re, .dmem_rdata, .wb_en, .wb_reg, .wb_data);

  assign imem_data  = imem[imem_addr[6:2]];
  assign dmem_rdata = dmem[dmem_addr[5:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;

  function automatic logic [31:0] rr(input int s, input int t, input int d, input logic [5:0] f);
    return {6'h00, s[4:0], t[4:0], d[4:0], 5'd0, f};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] o, input int s, input int t, input logic [15:0] k);
    return {o, s[4:0], t[4:0], k};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {pc, wb_en, wb_reg, wb_data, dmem_we, dmem_re}
  localparam int N = 16;
  localparam logic [71:0] TRACE [0:N-1] = '{
    {32'h00, 1'b1, 5'd1,  32'h5,        1'b0, 1'b0},
    {32'h04, 1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 1'b0},
    {32'h08, 1'b1, 5'd3,  32'h2,        1'b0, 1'b0},
    {32'h0C, 1'b1, 5'd4,  32'h8,        1'b0, 1'b0},
    {32'h10, 1'b1, 5'd5,  32'h5,        1'b0, 1'b0},
    {32'h14, 1'b1, 5'd6,  32'hFFFFFFFD, 1'b0, 1'b0},
    {32'h18, 1'b1, 5'd7,  32'h1,        1'b0, 1'b0},
    {32'h1C, 1'b0, 5'd0,  32'h0,        1'b1, 1'b0},
    {32'h20, 1'b1, 5'd8,  32'h8,        1'b0, 1'b1},
    {32'h24, 1'b0, 5'd0,  32'h0,        1'b0, 1'b0},
    {32'h28, 1'b0, 5'd0,  32'h0,        1'b0, 1'b0},
    {32'h2C, 1'b0, 5'd0,  32'h0,        1'b0, 1'b0},
    {32'h38, 1'b1, 5'd10, 32'h8,        1'b0, 1'b0},
    {32'h3C, 1'b1, 5'd11, 32'hA,        1'b0, 1'b0},
    {32'h40, 1'b0, 5'd0,  32'h0,        1'b0, 1'b0},
    {32'h40, 1'b0, 5'd0,  32'h0,        1'b0, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 13: return "R3 imm op";
      2, 3, 4, 5, 6: return "R2 reg op";
      7: return "R5 store";
      8: return "R4 load";
      9: return "R7 r0 write";
      10, 11, 14, 15: return "R6 branch";
      default: return "R9 forward";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) imem[i] = 32'hFC000000;
    for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
    imem[0]  = ri(6'h08, 0, 1, 16'd5);
    imem[1]  = ri(6'h08, 0, 2, 16'hFFFD);
    imem[2]  = rr(1, 2, 3, 6'h20);
    imem[3]  = rr(1, 2, 4, 6'h22);
    imem[4]  = rr(1, 2, 5, 6'h24);
    imem[5]  = rr(1, 2, 6, 6'h25);
    imem[6]  = rr(2, 1, 7, 6'h2A);
    imem[7]  = ri(6'h2B, 0, 4, 16'd8);
    imem[8]  = ri(6'h23, 0, 8, 16'd8);
    imem[9]  = ri(6'h08, 0, 0, 16'd7);
    imem[10] = ri(6'h04, 1, 2, 16'd5);
    imem[11] = ri(6'h04, 4, 8, 16'd2);
    imem[12] = ri(6'h08, 0, 9, 16'd1);
    imem[13] = ri(6'h08, 0, 9, 16'd2);
    imem[14] = rr(0, 8, 10, 6'h20);
    imem[15] = ri(6'h0E, 1, 11, 16'h000F);
    imem[16] = ri(6'h04, 0, 0, 16'hFFFF);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", imem_addr, 32'h0);
    rst = 1'b0;
    #0.5;
    for (int i = 0; i < N; i++) begin
      chk({tag_of(i), " pc"}, imem_addr, TRACE[i][71:40]);
      chk({tag_of(i), " wb_en"}, {31'd0, wb_en}, {31'd0, TRACE[i][39]});
      if (TRACE[i][39]) begin
        chk({tag_of(i), " wb_reg"}, {27'd0, wb_reg}, {27'd0, TRACE[i][38:34]});
        chk({tag_of(i), " wb_data"}, wb_data, TRACE[i][33:2]);
      end
      chk({tag_of(i), " we"}, {31'd0, dmem_we}, {31'd0, TRACE[i][1]});
      chk({tag_of(i), " re"}, {31'd0, dmem_re}, {31'd0, TRACE[i][0]});
      if (i == 7) begin
        chk("R5 store addr", dmem_addr, 32'h8);
        chk("R5 store data", dmem_wdata, 32'h8);
      end
      if (i == 8) chk("R4 load addr", dmem_addr, 32'h8);
      @(negedge clk);
      #0.5;
    end
    chk("R5 memory content", dmem[2], 32'h8);

    rst = 1'b1;
    imem[0] = rr(1, 0, 12, 6'h20);
    imem[1] = 32'hFC000000;
    imem[2] = ri(6'h08, 0, 13, 16'hFFFF);
    imem[3] = rr(13, 13, 14, 6'h3F);
    imem[4] = ri(6'h0A, 13, 15, 16'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc again", imem_addr, 32'h0);
    rst = 1'b0;
    #0.5;
    chk("R1 regs cleared wb_en", {31'd0, wb_en}, 32'd1);
    chk("R1 regs cleared data", wb_data, 32'h0);
    @(negedge clk); #0.5;
    chk("R8 unknown pc", imem_addr, 32'h4);
    chk("R8 unknown no wb", {31'd0, wb_en}, 32'd0);
    chk("R8 unknown no store", {31'd0, dmem_we}, 32'd0);
    @(negedge clk); #0.5;
    chk("R8 pc after unknown", imem_addr, 32'h8);
    chk("R3 sext imm", wb_data, 32'hFFFFFFFF);
    @(negedge clk); #0.5;
    chk("R2 bad funct no wb", {31'd0, wb_en}, 32'd0);
    @(negedge clk); #0.5;
    chk("R3 slti signed", wb_data, 32'h1);
    chk("R9 slti reg", {27'd0, wb_reg}, 32'd15);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule